// File: doc/BRIEF.md
# Supply Reset Pulse Generator

This block sequences the system reset of a supervisor. It watches two causes: a flag from an external comparator that is already synchronized to the block clock and is high while the supply sits below the reset threshold, and an active-low manual reset line driven by a push button or a peripheral. Whenever either cause is present, reset is asserted. Reset is released only after a full recovery interval has passed with no cause present.

The manual line first goes through a two-flop synchronizer. A qualification counter then requires the line to stay low for a set number of cycles. Short glitches are therefore discarded, while a press that is held down keeps reset asserted for as long as it lasts. Every interval is counted in clock cycles and derived from a clock-frequency parameter. A fast-simulation parameter replaces the long recovery interval with a short cycle count.

A manual line that is left floating or carries an unknown value is read as released, which stands in for an internal pull-up. The reset is offered in both polarities.

Top module: `rst_pulse_gen`

## Requirements
- R1: While the power-on input `por_n` is low, `rst_n_o` is 0 and `rst_o` is 1, with no dependence on the clock.
- R2: When `vlow_i` is 1 at a rising clock edge, reset is asserted after that edge and stays asserted while `vlow_i` remains 1.
- R3: After the last cause clears (power-on release, or `vlow_i` dropping to 0), `rst_n_o` goes to 1 exactly REC_CYC rising edges later. REC_CYC is SIM_REC_CYC when SIM_FAST=1, and CLK_HZ*REC_MS/1000 otherwise.
- R4: If `vlow_i` returns to 1 during a recovery interval, reset stays asserted and the full REC_CYC count restarts from the moment `vlow_i` falls again.
- R5: A low level on `mr_n_i` that lasts at least QUAL_CYC cycles asserts reset exactly QUAL_CYC+3 rising edges after the line falls, and reset stays asserted while the line is held low. QUAL_CYC is the ceiling of CLK_HZ*GLITCH_NS/1e9 and equals 6 at 50 MHz, which is 120 ns: at most 9 edges (180 ns) from press to reset.
- R6: A low pulse on `mr_n_i` that is shorter than QUAL_CYC cycles (100 ns or less at 50 MHz) has no effect on either reset output.
- R7: After an accepted manual reset, `rst_n_o` returns to 1 exactly REC_CYC+3 rising edges after `mr_n_i` returns high.
- R8: `rst_o` is always the exact inverse of `rst_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vlow_i | input | 1 | Synchronized flag: supply below threshold |
| mr_n_i | input | 1 | Manual reset request, active low; undriven reads as high |
| rst_n_o | output | 1 | Reset output, active low |
| rst_o | output | 1 | Reset output, active high |

## Verification
The embedded properties check several rules on every cycle. A supply-low flag forces reset on the next edge, and an accepted manual request does the same. Reset can only rise when a cause was present, and can only fall when no cause was present. Both counters stay within their bounds. The bench scenarios are the only way to show the exact cycle counts: the full recovery length, the restart after a dip, the nine-edge path from a press to reset, and the filtering of a five-cycle pulse against the acceptance of a six-cycle pulse.

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int REC_MS      = 140,
  parameter int GLITCH_NS   = 120,
  parameter bit SIM_FAST    = 1'b0,
  parameter int SIM_REC_CYC = 40
) (
  input  logic clk,
  input  logic por_n,
  input  logic vlow_i,
  input  logic mr_n_i,
  output logic rst_n_o,
  output logic rst_o
);
  localparam longint REAL_REC = longint'(CLK_HZ) * REC_MS / 1000;
  localparam int REC_CYC  = SIM_FAST ? SIM_REC_CYC : int'(REAL_REC);
  localparam int REC_W    = $clog2(REC_CYC + 1);
  localparam int QUAL_CYC = int'((longint'(CLK_HZ) * GLITCH_NS + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int QUAL_W   = $clog2(QUAL_CYC + 1);

  // An undriven or unknown line reads as released.
  wire mr_raw = (mr_n_i !== 1'b0);

  logic [1:0]        mr_sync;
  logic [QUAL_W-1:0] qual_cnt;
  logic [REC_W-1:0]  rec_cnt;
  logic              rst_q;

  wire mr_ok = (qual_cnt == QUAL_W'(QUAL_CYC));
  wire cause = vlow_i | mr_ok;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) mr_sync <= 2'b11;
    else        mr_sync <= {mr_sync[0], mr_raw};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)               qual_cnt <= '0;
    else if (mr_sync[1])      qual_cnt <= '0;
    else if (!mr_ok)          qual_cnt <= qual_cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rst_q   <= 1'b1;
      rec_cnt <= '0;
    end else if (cause) begin
      rst_q   <= 1'b1;
      rec_cnt <= '0;
    end else if (rst_q) begin
      if (rec_cnt == REC_W'(REC_CYC - 1)) rst_q <= 1'b0;
      else                                rec_cnt <= rec_cnt + 1'b1;
    end

  assign rst_o   = rst_q;
  assign rst_n_o = ~rst_q;

  AST_VLOW_FORCES: assert property (@(posedge clk) disable iff (!por_n)
    vlow_i |=> rst_o); // R2
  AST_MR_FORCES: assert property (@(posedge clk) disable iff (!por_n)
    mr_ok |=> rst_o); // R5
  AST_RISE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_o) |-> $past(vlow_i || mr_ok)); // R6
  AST_FALL_NO_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o) |-> $past(!vlow_i && !mr_ok)); // R3
  AST_REC_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    rec_cnt <= REC_W'(REC_CYC - 1)); // R3
  AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    qual_cnt <= QUAL_W'(QUAL_CYC)); // R6
endmodule

// File: tb/rst_pulse_gen_tb_top.sv
module rst_pulse_gen_tb_top;
  localparam int REC  = 40;
  localparam int QUAL = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, vlow = 1'b0, mr_n = 1'b1;
  logic rst_n_o, rst_o;
  int total = 0, bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  rst_pulse_gen #(.CLK_HZ(50_000_000), .REC_MS(140), .GLITCH_NS(120),
                  .SIM_FAST(1'b1), .SIM_REC_CYC(REC)) dut_i (
    .clk(clk), .por_n(por_n), .vlow_i(vlow), .mr_n_i(mr_n),
    .rst_n_o(rst_n_o), .rst_o(rst_o));

  task automatic push(input string tag, input int e);
    tag_q.push_back(tag); exp_q.push_back(e);
  endtask

  task automatic pop_cmp(input int act);
    string t; int e;
    t = tag_q.pop_front(); e = exp_q.pop_front();
    total++;
    if (act != e) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, e);
    end
  endtask

  // counts rising edges until rst_n_o equals lvl; sampled at negedge
  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_n_o === lvl) break;
    end
  endtask

  // monitor: R8 at every sample
  int inv_bad = 0;
  always @(negedge clk) if (por_n && rst_o !== ~rst_n_o) inv_bad++;

  initial begin
    int n;
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, held;
    repeat (3) @(negedge clk);
    push("R1 rst_n_o in por", 0); pop_cmp(rst_n_o);
    push("R1 rst_o in por", 1);   pop_cmp(rst_o);
    push("R8 inverse in por", 1); pop_cmp(int'(rst_o == ~rst_n_o));

    por_n = 1'b1;
    push("R3 release after por", REC);
    edges_until(1'b1, n); pop_cmp(n);

    repeat (5) @(negedge clk);
    vlow = 1'b1;
    push("R2 assert on vlow", 1);
    edges_until(1'b0, n); pop_cmp(n);
    held = 0;
    repeat (20) begin @(negedge clk); if (rst_n_o !== 1'b0) held++; end
    push("R2 held while vlow", 0); pop_cmp(held);
    vlow = 1'b0;
    push("R3 release after vlow", REC);
    edges_until(1'b1, n); pop_cmp(n);

    repeat (5) @(negedge clk);
    vlow = 1'b1; @(negedge clk); vlow = 1'b0;
    repeat (20) @(negedge clk);
    vlow = 1'b1; @(negedge clk);
    push("R4 still asserted on dip", 0); pop_cmp(rst_n_o);
    vlow = 1'b0;
    push("R4 full restart", REC);
    edges_until(1'b1, n); pop_cmp(n);

    repeat (5) @(negedge clk);
    mr_n = 1'b0; repeat (QUAL - 1) @(negedge clk); mr_n = 1'b1;
    held = 0;
    repeat (REC + 10) begin @(negedge clk); if (rst_n_o !== 1'b1) held++; end
    push("R6 short pulse ignored", 0); pop_cmp(held);

    mr_n = 1'b0; @(negedge clk); mr_n = 1'b1;
    held = 0;
    repeat (12) begin @(negedge clk); if (rst_n_o !== 1'b1) held++; end
    push("R6 one-cycle pulse ignored", 0); pop_cmp(held);

    mr_n = 1'b0;
    push("R5 press-to-reset edges", QUAL + 3);
    edges_until(1'b0, n); pop_cmp(n);
    repeat (QUAL + 3) @(negedge clk);
    mr_n = 1'b1;
    edges_until(1'b1, n);
    push("R5 minimum pulse gave full recovery", 1); pop_cmp(int'(n > REC - QUAL));

    repeat (5) @(negedge clk);
    mr_n = 1'b0;
    edges_until(1'b0, n);
    held = 0;
    repeat (60) begin @(negedge clk); if (rst_n_o !== 1'b0) held++; end
    push("R5 held during long press", 0); pop_cmp(held);
    mr_n = 1'b1;
    push("R7 release after manual", REC + 3);
    edges_until(1'b1, n); pop_cmp(n);

    push("R8 inverse every cycle", 0); pop_cmp(inv_bad);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule